// File: doc/BRIEF.md
# Sub-Predictor Hint Buffer with Table Gating

This block sits beside a combined branch predictor, whose two direction tables (a global-history gshare table and a per-address bimodal table) are arbitrated by a selector table. It keeps a short ring of the most recently fetched branches. Each entry holds the branch address and a two-bit code recording which direction table last supplied that branch's outcome.

Up to two branches are entered per fetch cycle. The block returns each new entry's slot number, and the resolution logic later uses that slot to write the hint. At the end of every fetch cycle the last fetched branch address is searched. If that branch was seen earlier, the two entries that followed it predict which tables the next two branches will need. When both name the same direction table and both are trusted, the selector and the other direction table are clock-gated for the following cycle. In every other case all three tables stay on.

A mispredicted branch only has its own hint marked. The entries younger than it are kept, so their hints remain usable.

Top module: `hint_gate_fifo`

## Requirements
- R1: A valid lane-0 allocation writes slot `alloc0_idx`. A lane-1 allocation in the same cycle writes slot `alloc1_idx` (the next slot) and is accepted only when lane 0 is also valid. The write pointer advances by the number of accepted entries, modulo DEPTH, and the oldest entry is overwritten once the ring is full.
- R2: A newly allocated entry carries hint code 2'b10 (pending). A pending follower never allows gating.
- R3: An update writes the hint of slot `upd_idx`. The code is 2'b11 if `upd_mispred` is set; otherwise it is 2'b00 when `upd_src`=0 (gshare) or 2'b01 when `upd_src`=1 (bimodal). An allocation to the same slot in the same cycle takes precedence.
- R4: A lookup searches the contents as they stood at the start of its cycle. If several entries match, the youngest match is used. The resulting enables appear on the outputs one clock later.
- R5: If both followers hold 2'b00, the next enables are gshare=1, bimodal=0, selector=0. If both hold 2'b01, they are gshare=0, bimodal=1, selector=0.
- R6: Any other pair of follower codes (mixed codes, 2'b10 or 2'b11) leaves all three enables at 1.
- R7: A lookup miss, an idle lookup cycle, or a match with fewer than two younger entries sets all three enables to 1.
- R8: Reset clears every entry, sets the write pointer to slot 0 and drives all three enables to 1.
- R9: A mispredict update changes only its own slot. Younger entries keep their hints and can still produce gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc0_valid | input | 1 | Enter the first (older) fetched branch |
| alloc0_addr | input | AW | Address of the first fetched branch |
| alloc1_valid | input | 1 | Enter the second fetched branch |
| alloc1_addr | input | AW | Address of the second fetched branch |
| alloc0_idx | output | log2(DEPTH) | Slot given to the lane-0 branch |
| alloc1_idx | output | log2(DEPTH) | Slot given to the lane-1 branch |
| upd_valid | input | 1 | Write a resolved hint |
| upd_idx | input | log2(DEPTH) | Slot to write |
| upd_mispred | input | 1 | Branch was mispredicted |
| upd_src | input | 1 | Direction table used: 0 gshare, 1 bimodal |
| lkp_valid | input | 1 | A lookup is requested this cycle |
| lkp_addr | input | AW | Last fetched branch address |
| en_gshare | output | 1 | Gshare table enable for the next cycle |
| en_bimodal | output | 1 | Bimodal table enable for the next cycle |
| en_select | output | 1 | Selector table enable for the next cycle |

## Verification
The slot numbers are combinational from the write pointer, so they are due in the same cycle as the allocation request. Hints and new entries become visible to lookups in the cycle after they are written. Enables are due exactly one clock after the lookup cycle.

The bench changes its inputs one time unit after a rising edge. It computes the expected enables from its own model as that model stood before the edge, then advances the model. It compares the enables one time unit after the next edge and checks the slot numbers before that edge.

// File: rtl/hfg_pkg.sv
package hfg_pkg;
   typedef enum logic [1:0] {
      HINT_GSHARE  = 2'b00,
      HINT_BIMODAL = 2'b01,
      HINT_PEND    = 2'b10,
      HINT_MISS    = 2'b11
   } hint_e;
endpackage

// File: rtl/hfg_store.sv
module hfg_store
   import hfg_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = 32,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         a0_v,
   input  logic [AW-1:0]                a0_addr,
   input  logic                         a1_v,
   input  logic [AW-1:0]                a1_addr,
   input  logic                         u_v,
   input  logic [IW-1:0]                u_idx,
   input  logic                         u_miss,
   input  logic                         u_src,
   output logic [IW-1:0]                wp,
   output logic [DEPTH-1:0]             vld,
   output logic [DEPTH-1:0][AW-1:0]     addr,
   output logic [DEPTH-1:0][1:0]        hint
);
   logic [1:0]    u_code;
   logic [IW-1:0] wp_nx1;

   assign u_code = u_miss ? HINT_MISS : (u_src ? HINT_BIMODAL : HINT_GSHARE);
   assign wp_nx1 = wp + IW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp   <= '0;
         vld  <= '0;
         addr <= '0;
         for (int i = 0; i < DEPTH; i++) hint[i] <= HINT_PEND;
      end else begin
         if (u_v) hint[u_idx] <= u_code;
         if (a0_v) begin
            vld[wp]  <= 1'b1;
            addr[wp] <= a0_addr;
            hint[wp] <= HINT_PEND;
            if (a1_v) begin
               vld[wp_nx1]  <= 1'b1;
               addr[wp_nx1] <= a1_addr;
               hint[wp_nx1] <= HINT_PEND;
               wp <= wp + IW'(2);
            end else begin
               wp <= wp_nx1;
            end
         end
      end
   end
endmodule

// File: rtl/hfg_match.sv
module hfg_match
   import hfg_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = 32,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic                     lkp_v,
   input  logic [AW-1:0]            lkp_addr,
   input  logic [IW-1:0]            wp,
   input  logic [DEPTH-1:0]         vld,
   input  logic [DEPTH-1:0][AW-1:0] addr,
   input  logic [DEPTH-1:0][1:0]    hint,
   output logic                     ok,
   output logic [1:0]               h1,
   output logic [1:0]               h2
);
   logic [DEPTH-1:0] eq;
   logic             found;
   logic [IW-1:0]    sel;
   logic [IW-1:0]    sel_age;
   logic [IW-1:0]    slot;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      assign eq[i] = vld[i] && (addr[i] == lkp_addr);
   end

   // Walk from youngest to oldest; first hit is the youngest match.
   always_comb begin
      found   = 1'b0;
      sel     = '0;
      sel_age = '0;
      slot    = '0;
      for (int k = 0; k < DEPTH; k++) begin
         slot = wp - IW'(1) - IW'(k);
         if (!found && eq[slot]) begin
            found   = 1'b1;
            sel     = slot;
            sel_age = IW'(k);
         end
      end
   end

   assign ok = lkp_v && found && (sel_age >= IW'(2));
   assign h1 = hint[sel + IW'(1)];
   assign h2 = hint[sel + IW'(2)];
endmodule

// File: rtl/hfg_gate.sv
module hfg_gate
   import hfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ok,
   input  logic [1:0] h1,
   input  logic [1:0] h2,
   output logic       en_g,
   output logic       en_b,
   output logic       en_s
);
   logic same;
   assign same = ok && (h1 == h2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         {en_g, en_b, en_s} <= 3'b111;
      end else if (same && h1 == HINT_GSHARE) begin
         {en_g, en_b, en_s} <= 3'b100;
      end else if (same && h1 == HINT_BIMODAL) begin
         {en_g, en_b, en_s} <= 3'b010;
      end else begin
         {en_g, en_b, en_s} <= 3'b111;
      end
   end
endmodule

// File: rtl/hint_gate_fifo.sv
module hint_gate_fifo
   import hfg_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = 32,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc0_valid,
   input  logic [AW-1:0] alloc0_addr,
   input  logic          alloc1_valid,
   input  logic [AW-1:0] alloc1_addr,
   output logic [IW-1:0] alloc0_idx,
   output logic [IW-1:0] alloc1_idx,
   input  logic          upd_valid,
   input  logic [IW-1:0] upd_idx,
   input  logic          upd_mispred,
   input  logic          upd_src,
   input  logic          lkp_valid,
   input  logic [AW-1:0] lkp_addr,
   output logic          en_gshare,
   output logic          en_bimodal,
   output logic          en_select
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("hint_gate_fifo: DEPTH must be a power of two, at least 4");
   end
   if (AW < 1) begin : g_bad_aw
      $error("hint_gate_fifo: AW must be positive");
   end

   logic [IW-1:0]              wp;
   logic [DEPTH-1:0]           vld;
   logic [DEPTH-1:0][AW-1:0]   addr;
   logic [DEPTH-1:0][1:0]      hint;
   logic                       ok;
   logic [1:0]                 h1, h2;

   hfg_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
      .clk(clk), .rst_n(rst_n),
      .a0_v(alloc0_valid), .a0_addr(alloc0_addr),
      .a1_v(alloc1_valid), .a1_addr(alloc1_addr),
      .u_v(upd_valid), .u_idx(upd_idx), .u_miss(upd_mispred), .u_src(upd_src),
      .wp(wp), .vld(vld), .addr(addr), .hint(hint)
   );

   hfg_match #(.DEPTH(DEPTH), .AW(AW)) u_match (
      .lkp_v(lkp_valid), .lkp_addr(lkp_addr), .wp(wp),
      .vld(vld), .addr(addr), .hint(hint),
      .ok(ok), .h1(h1), .h2(h2)
   );

   hfg_gate u_gate (
      .clk(clk), .rst_n(rst_n), .ok(ok), .h1(h1), .h2(h2),
      .en_g(en_gshare), .en_b(en_bimodal), .en_s(en_select)
   );

   assign alloc0_idx = wp;
   assign alloc1_idx = wp + IW'(1);
endmodule

// File: rtl/hint_gate_fifo_chk.sv
module hint_gate_fifo_chk #(
   parameter int IW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          alloc0_valid,
   input logic          alloc1_valid,
   input logic [IW-1:0] alloc0_idx,
   input logic          lkp_valid,
   input logic          en_gshare,
   input logic          en_bimodal,
   input logic          en_select
);
   a_r1_ptr_two: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc0_valid && alloc1_valid) |=> alloc0_idx == $past(alloc0_idx) + IW'(2));
   a_r1_ptr_one: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc0_valid && !alloc1_valid) |=> alloc0_idx == $past(alloc0_idx) + IW'(1));
   a_r1_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !alloc0_valid |=> $stable(alloc0_idx));
   a_r7_idle_all_on: assert property (@(posedge clk) disable iff (!rst_n)
      !lkp_valid |=> (en_gshare && en_bimodal && en_select));
   a_r5_single_table: assert property (@(posedge clk) disable iff (!rst_n)
      !en_select |-> (en_gshare != en_bimodal));
   a_r6_direction_kept: assert property (@(posedge clk) disable iff (!rst_n)
      en_gshare || en_bimodal);
   a_r8_leave_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (en_gshare && en_bimodal && en_select));
endmodule

bind hint_gate_fifo hint_gate_fifo_chk #(.IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .alloc0_valid(alloc0_valid), .alloc1_valid(alloc1_valid),
   .alloc0_idx(alloc0_idx), .lkp_valid(lkp_valid),
   .en_gshare(en_gshare), .en_bimodal(en_bimodal), .en_select(en_select)
);

// File: tb/sim_hint_gate_fifo.sv
module sim_hint_gate_fifo;
   localparam int CLK_PERIOD = 10;
   localparam int D  = 8;
   localparam int AW = 16;
   localparam int IW = $clog2(D);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          a0v = 0, a1v = 0, uv = 0, umiss = 0, usrc = 0, lv = 0;
   logic [AW-1:0] a0a = '0, a1a = '0, la = '0;
   logic [IW-1:0] uidx = '0;
   logic [IW-1:0] i0, i1;
   logic          eg, eb, es;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural model
   int m_wp;
   bit m_vld [D];
   int m_addr[D];
   int m_hint[D];

   always #(CLK_PERIOD/2) clk = ~clk;

   hint_gate_fifo #(.DEPTH(D), .AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .alloc0_valid(a0v), .alloc0_addr(a0a),
      .alloc1_valid(a1v), .alloc1_addr(a1a),
      .alloc0_idx(i0), .alloc1_idx(i1),
      .upd_valid(uv), .upd_idx(uidx), .upd_mispred(umiss), .upd_src(usrc),
      .lkp_valid(lv), .lkp_addr(la),
      .en_gshare(eg), .en_bimodal(eb), .en_select(es)
   );

   task automatic chk(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int model_en(bit v, int a);
      int age;
      int s;
      int h1, h2;
      age = -1;
      s = 0;
      if (!v) return 3'b111;
      for (int k = 0; k < D; k++) begin
         int sl;
         sl = ((m_wp - 1 - k) % D + D) % D;
         if (age < 0 && m_vld[sl] && m_addr[sl] == a) begin
            age = k;
            s = sl;
         end
      end
      if (age < 2) return 3'b111;
      h1 = m_hint[(s + 1) % D];
      h2 = m_hint[(s + 2) % D];
      if (h1 == h2 && h1 == 0) return 3'b100;
      if (h1 == h2 && h1 == 1) return 3'b010;
      return 3'b111;
   endfunction

   task automatic model_reset();
      m_wp = 0;
      for (int i = 0; i < D; i++) begin
         m_vld[i] = 0; m_addr[i] = 0; m_hint[i] = 2;
      end
   endtask

   // one cycle: drive, check slot numbers, predict, clock, compare
   task automatic cyc(string req, bit p0v, int p0a, bit p1v, int p1a,
                      bit puv, int pidx, bit pmiss, bit psrc,
                      bit plv, int pla);
      int exp;
      a0v = p0v; a0a = AW'(p0a); a1v = p1v; a1a = AW'(p1a);
      uv = puv; uidx = IW'(pidx); umiss = pmiss; usrc = psrc;
      lv = plv; la = AW'(pla);
      #1;
      chk("R1", int'(i0), m_wp, "alloc0_idx");
      chk("R1", int'(i1), (m_wp + 1) % D, "alloc1_idx");
      exp = model_en(plv, pla);
      @(posedge clk);
      #1;
      if (puv) m_hint[pidx] = pmiss ? 3 : (psrc ? 1 : 0);
      if (p0v) begin
         m_vld[m_wp] = 1; m_addr[m_wp] = p0a; m_hint[m_wp] = 2;
         m_wp = (m_wp + 1) % D;
         if (p1v) begin
            m_vld[m_wp] = 1; m_addr[m_wp] = p1a; m_hint[m_wp] = 2;
            m_wp = (m_wp + 1) % D;
         end
      end
      chk(req, int'({eg, eb, es}), exp, "enables");
   endtask

   task automatic idle(string req);
      cyc(req, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic al2(int a, int b);
      cyc("R1", 1, a, 1, b, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic al1(int a);
      cyc("R1", 1, a, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic upd(int idx, bit miss, bit src);
      cyc("R3", 0, 0, 0, 0, 1, idx, miss, src, 0, 0);
   endtask
   task automatic look(string req, int a, int exp_code);
      cyc(req, 0, 0, 0, 0, 0, 0, 0, 0, 1, a);
      chk(req, int'({eg, eb, es}), exp_code, "fixed expectation");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      chk("R8", int'({eg, eb, es}), 3'b111, "enables in reset");
      rst_n = 1'b1;
      idle("R8");
      chk("R8", int'(i0), 0, "pointer after reset");

      // gshare pair after A -> gate to gshare (R5)
      al2(100, 200); al1(300);                 // slots 0,1,2
      look("R2", 100, 3'b111);                 // followers pending
      upd(1, 0, 0); upd(2, 0, 0);
      look("R5", 100, 3'b100);
      idle("R4");                              // enables return high
      // bimodal pair
      al2(400, 500); al1(600);                 // slots 3,4,5
      upd(4, 0, 1); upd(5, 0, 1);
      look("R5", 400, 3'b010);
      // mixed pair
      upd(5, 0, 0);
      look("R6", 400, 3'b111);
      // mispredicted follower
      upd(5, 1, 0); upd(4, 0, 0);
      look("R6", 400, 3'b111);
      // miss, and too few followers
      look("R7", 999, 3'b111);
      look("R7", 500, 3'b111);                 // one younger entry
      look("R7", 600, 3'b111);                 // none younger
      // R9: older mispredict leaves younger usable
      upd(0, 1, 0);
      look("R9", 100, 3'b100);
      // R4: lookup and update in the same cycle use old contents
      cyc("R4", 0, 0, 0, 0, 1, 2, 1, 0, 1, 100);
      chk("R4", int'({eg, eb, es}), 3'b100, "pre-update hint used");
      look("R4", 100, 3'b111);
      // R1: lane 1 ignored without lane 0
      cyc("R1", 0, 0, 1, 777, 0, 0, 0, 0, 0, 0);
      look("R1", 777, 3'b111);
      // R4 youngest match: 300 again at slots 6, followers 7 and 0 (wrap)
      al2(300, 800); al1(900);                 // slots 6,7,0
      upd(7, 0, 1); upd(0, 0, 1);
      look("R4", 300, 3'b010);
      // R3 allocation beats update to same slot
      cyc("R3", 1, 1000, 0, 0, 1, 1, 0, 1, 0, 0);  // slot 1
      al1(1100);                               // slot 2
      upd(2, 0, 1);
      look("R3", 900, 3'b111);                 // slot 1 still pending
      // R1 wrap: 100 was at slot 0 and has been overwritten
      look("R1", 100, 3'b111);

      // random traffic against the model
      for (int n = 0; n < 3000; n++) begin
         bit r0, r1, ru, rl;
         r0 = ($urandom % 3) == 0;
         r1 = ($urandom % 2) == 0;
         ru = ($urandom % 2) == 0;
         rl = ($urandom % 4) != 0;
         cyc("R5", r0, 10 + $urandom % 5, r1, 10 + $urandom % 5,
             ru, $urandom % D, ($urandom % 6) == 0, $urandom % 2,
             rl, 10 + $urandom % 5);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule